// File: doc/BRIEF.md
# Serial-Port Successive-Approximation Converter Core

This block is the digital side of an 8-bit successive-approximation analog-to-digital converter that a host controls over a three-wire serial link. The host pulls chip select low and toggles the serial clock. On that clock the block waits for a start bit and takes in a short multiplexer word. It decodes the word into positive, negative and common-pin channel selects for the analog front end. After a settling gap it runs the binary search against an external comparator. Each decision goes back to the host the moment it is made, with the most significant bit first. The finished result is then replayed with the least significant bit first.

The whole block runs on one fast system clock. The serial clock, chip select, data-in and shift-enable pins pass through a synchronizer of `SYNC_STAGES` flops, and the block reacts to the detected edges of the serial clock. The serial data output is a value bit plus a drive-enable bit. An output buffer outside the block turns these into a tri-state pad. The capacitor array, resistor ladder and comparator also sit outside the block. They see the trial code on `dacCode` and return one decision bit on `cmpIn`.

Top module: `sar_serial_core`

## Requirements
- R1: While reset is held or chip select is high, `doEn`, `doData` and `busy` are 0, all channel selects are 0 and `dacCode` is 0.
- R2: With chip select low, each rising serial edge samples data-in. Zeros before the first 1 are discarded. That first 1 is the start bit, and the next four sampled bits form the mux word, most significant first.
- R3: In the mux word, bit 3 is the mode and bits 2:0 are the channel index. Mode 1 (single-ended) gives `posSel` = one-hot(index), `comSel` = 1 and `negSel` = 0. Mode 0 (differential) gives `posSel` = one-hot(index), `negSel` = one-hot(index XOR 1) and `comSel` = 0.
- R4: On the falling edge after the last mux bit, `doEn` goes to 1 and `doData` drives 0. On the following rising edge `busy` goes to 1. `busy` is only ever 1 while `doEn` is 1.
- R5: The conversion starts with `dacCode` = 0x80. On each of eight falling edges the block samples `cmpIn`. It keeps the trial bit when `cmpIn` is 1 and clears it otherwise, sets the next lower bit, and drives the decision onto `doData` (MSB first). The result is positive minus negative input, clamped to 0..255, and it is 0x00 when the positive input is the lower one.
- R6: `busy` stays 1 through the eight decisions and falls on the rising edge after the eighth. The channel selects do not change while `busy` is 1.
- R7: After the conversion, `doData` holds result bit 0 for every falling edge at which shift-enable is 1. Each falling edge with shift-enable 0 then presents bits 1 through 7 in turn. After bit 7, `doData` is 0 with `doEn` at 1 until chip select rises.
- R8: Once the mux word is captured, data-in has no effect on the selects or the result until chip select rises.
- R9: If chip select rises at any point, the block is idle (`busy` = 0, `doEn` = 0, selects 0) within `SYNC_STAGES`+1 system clocks.
- R10: `posSel` and `negSel` are each one-hot or all-zero, and `negSel` is 0 whenever `comSel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| csN | input | 1 | Active-low chip select |
| din | input | 1 | Serial data in (start bit and mux word) |
| shiftEn | input | 1 | High holds the LSB on the output; low lets the LSB-first replay advance |
| cmpIn | input | 1 | Comparator decision: 1 when the input is at or above the trial level |
| dacCode | output | RES (8) | Trial code for the capacitor/ladder network |
| posSel | output | NUM_CH (8) | One-hot positive-input channel select |
| negSel | output | NUM_CH (8) | One-hot negative-input channel select |
| comSel | output | 1 | Common pin used as the negative input |
| busy | output | 1 | Conversion in progress |
| doData | output | 1 | Serial data out value |
| doEn | output | 1 | Serial data out drive enable (0 = high impedance) |

## Verification
Every serial-clock edge reaches the outputs `SYNC_STAGES`+1 system clocks after it happens, which is three clocks with the defaults. The bench holds each serial half-period for eight system clocks and reads the outputs at the end of the half-period, just before the next edge. Decision bits and replay bits are therefore checked at the end of each low phase. `busy`, the selects and the start code 0x80 are checked at the end of each high phase. After chip select rises in the middle of a conversion, the bench waits five system clocks before it checks for idle, which leaves margin over the three-clock bound.

// File: rtl/sar_serial_pkg.sv
`timescale 1ns/1ps
package sar_serial_pkg;

  // Per-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic clear;      // drop everything back to idle values
    logic addrShift;  // shift synchronized data-in into the mux word
    logic selLatch;   // decode the completed mux word into channel selects
    logic convStart;  // load the first trial code
    logic decide;     // apply one comparator decision
    logic outLoad;    // copy the finished result into the replay register
    logic outShift;   // present the next replay bit
    logic doZero;     // force the serial output bit low
  } sarStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HUNT,
    ST_ADDR,
    ST_SETL_F,
    ST_SETL_R,
    ST_CONV,
    ST_CEND,
    ST_OUTP,
    ST_TAIL
  } sarState_t;

endpackage

// File: rtl/sar_serial_sync.sv
`timescale 1ns/1ps
// Brings the four host pins into the clk domain and finds serial-clock edges.
module sar_serial_sync #(
  parameter int STAGES = 2   // must be 2 or more
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  input  logic dinIn,
  input  logic seIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csActive,
  output logic dinSync,
  output logic seSync
);

  localparam int NPINS = 4;
  localparam logic [NPINS-1:0] RST_VAL = 4'b0010; // chip select parks inactive

  logic [NPINS-1:0] pipe [STAGES];
  logic             sclkPrev;
  logic [NPINS-1:0] last;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      sclkPrev <= 1'b0;
    end else begin
      pipe[0] <= {seIn, dinIn, csNIn, sclkIn};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sclkPrev <= pipe[STAGES-1][0];
    end
  end

  assign last     = pipe[STAGES-1];
  assign sclkRise = last[0] & ~sclkPrev;
  assign sclkFall = ~last[0] & sclkPrev;
  assign csActive = ~last[1];
  assign dinSync  = last[2];
  assign seSync   = last[3];

endmodule

// File: rtl/sar_serial_ctrl.sv
`timescale 1ns/1ps
// Sequencer: start-bit hunt, mux capture, settling, eight decisions, replay.
module sar_serial_ctrl
  import sar_serial_pkg::*;
#(
  parameter int RES      = 8,
  parameter int MUX_BITS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkRise,
  input  logic       sclkFall,
  input  logic       csActive,
  input  logic       dinSync,
  input  logic       seSync,
  output sarStrobe_t strobe,
  output logic       busy,
  output logic       doEn
);

  localparam int CNT_MAX = (RES > MUX_BITS) ? RES : MUX_BITS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  sarState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             busyNext, doEnNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    cntNext   = cnt;
    busyNext  = busy;
    doEnNext  = doEn;
    if (!csActive) begin
      strobe.clear = 1'b1;
      stateNext    = ST_IDLE;
      cntNext      = '0;
      busyNext     = 1'b0;
      doEnNext     = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: stateNext = ST_HUNT;
        ST_HUNT: begin
          if (sclkRise && dinSync) begin
            stateNext = ST_ADDR;
            cntNext   = '0;
          end
        end
        ST_ADDR: begin
          if (sclkRise) begin
            strobe.addrShift = 1'b1;
            if (cnt == CNT_W'(MUX_BITS - 1)) begin
              strobe.selLatch = 1'b1;
              stateNext       = ST_SETL_F;
              cntNext         = '0;
            end else begin
              cntNext = cnt + 1'b1;
            end
          end
        end
        ST_SETL_F: begin
          if (sclkFall) begin
            strobe.doZero = 1'b1;
            doEnNext      = 1'b1;
            stateNext     = ST_SETL_R;
          end
        end
        ST_SETL_R: begin
          if (sclkRise) begin
            strobe.convStart = 1'b1;
            busyNext         = 1'b1;
            stateNext        = ST_CONV;
            cntNext          = '0;
          end
        end
        ST_CONV: begin
          if (sclkFall) begin
            strobe.decide = 1'b1;
            if (cnt == CNT_W'(RES - 1)) begin
              stateNext = ST_CEND;
              cntNext   = '0;
            end else begin
              cntNext = cnt + 1'b1;
            end
          end
        end
        ST_CEND: begin
          if (sclkRise) begin
            strobe.outLoad = 1'b1;
            busyNext       = 1'b0;
            stateNext      = ST_OUTP;
          end
        end
        ST_OUTP: begin
          if (sclkFall && !seSync) begin
            if (cnt == CNT_W'(RES - 1)) begin
              strobe.doZero = 1'b1;
              stateNext     = ST_TAIL;
            end else begin
              strobe.outShift = 1'b1;
              cntNext         = cnt + 1'b1;
            end
          end
        end
        ST_TAIL: stateNext = ST_TAIL;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      busy  <= 1'b0;
      doEn  <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      busy  <= busyNext;
      doEn  <= doEnNext;
    end
  end

endmodule

// File: rtl/sar_serial_dp.sv
`timescale 1ns/1ps
// Datapath: mux word, channel decode, trial register, replay register, output bit.
module sar_serial_dp
  import sar_serial_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobe_t        strobe,
  input  logic              dinSync,
  input  logic              cmpIn,
  output logic [RES-1:0]    dacCode,
  output logic [NUM_CH-1:0] posSel,
  output logic [NUM_CH-1:0] negSel,
  output logic              comSel,
  output logic              doBit
);

  localparam int CH_W     = $clog2(NUM_CH);
  localparam int MUX_BITS = CH_W + 1;
  localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

  logic [MUX_BITS-1:0] addrReg;
  logic [MUX_BITS-1:0] word;
  logic                singleMode;
  logic [CH_W-1:0]     chIdx;
  logic [NUM_CH-1:0]   posDec, negDec;
  logic [RES-1:0]      sarReg, maskReg, outSh;

  // the last mux bit arrives in the same cycle as the latch strobe
  assign word       = {addrReg[MUX_BITS-2:0], dinSync};
  assign singleMode = word[MUX_BITS-1];
  assign chIdx      = word[CH_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : gDecode
    assign posDec[g] = (chIdx == CH_W'(g));
    assign negDec[g] = ~singleMode & (chIdx == CH_W'(g ^ 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      posSel  <= '0;
      negSel  <= '0;
      comSel  <= 1'b0;
    end else if (strobe.clear) begin
      addrReg <= '0;
      posSel  <= '0;
      negSel  <= '0;
      comSel  <= 1'b0;
    end else begin
      if (strobe.addrShift) addrReg <= word;
      if (strobe.selLatch) begin
        posSel <= posDec;
        negSel <= negDec;
        comSel <= singleMode;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg  <= '0;
      maskReg <= '0;
      outSh   <= '0;
      doBit   <= 1'b0;
    end else if (strobe.clear) begin
      sarReg  <= '0;
      maskReg <= '0;
      outSh   <= '0;
      doBit   <= 1'b0;
    end else begin
      if (strobe.convStart) begin
        sarReg  <= TOP_BIT;
        maskReg <= TOP_BIT;
      end
      if (strobe.decide) begin
        sarReg  <= (cmpIn ? sarReg : (sarReg & ~maskReg)) | (maskReg >> 1);
        maskReg <= maskReg >> 1;
        doBit   <= cmpIn;
      end
      if (strobe.outLoad) outSh <= sarReg;
      if (strobe.outShift) begin
        outSh <= outSh >> 1;
        doBit <= outSh[1];
      end
      if (strobe.doZero) doBit <= 1'b0;
    end
  end

  assign dacCode = sarReg;

endmodule

// File: rtl/sar_serial_core.sv
`timescale 1ns/1ps
module sar_serial_core
  import sar_serial_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int RES         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              din,
  input  logic              shiftEn,
  input  logic              cmpIn,
  output logic [RES-1:0]    dacCode,
  output logic [NUM_CH-1:0] posSel,
  output logic [NUM_CH-1:0] negSel,
  output logic              comSel,
  output logic              busy,
  output logic              doData,
  output logic              doEn
);

  localparam int MUX_BITS = $clog2(NUM_CH) + 1;

  logic       sclkRise, sclkFall, csActive, dinSync, seSync;
  sarStrobe_t strobe;

  sar_serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .sclkIn(sclk), .csNIn(csN), .dinIn(din), .seIn(shiftEn),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csActive(csActive),
    .dinSync(dinSync), .seSync(seSync)
  );

  sar_serial_ctrl #(.RES(RES), .MUX_BITS(MUX_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csActive(csActive),
    .dinSync(dinSync), .seSync(seSync),
    .strobe(strobe), .busy(busy), .doEn(doEn)
  );

  sar_serial_dp #(.NUM_CH(NUM_CH), .RES(RES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dinSync(dinSync), .cmpIn(cmpIn),
    .dacCode(dacCode), .posSel(posSel), .negSel(negSel), .comSel(comSel),
    .doBit(doData)
  );

endmodule

// File: rtl/sar_serial_chk.sv
`timescale 1ns/1ps
module sar_serial_chk #(
  parameter int NUM_CH      = 8,
  parameter int RES         = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              busy,
  input logic              doEn,
  input logic              doData,
  input logic [RES-1:0]    dacCode,
  input logic [NUM_CH-1:0] posSel,
  input logic [NUM_CH-1:0] negSel,
  input logic              comSel
);

  localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

  // consecutive cycles with chip select high, saturating
  logic [4:0] csHighCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          csHighCnt <= '0;
    else if (!csN)                      csHighCnt <= '0;
    else if (csHighCnt != 5'd31)        csHighCnt <= csHighCnt + 5'd1;
  end

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(posSel) && $onehot0(negSel));

  assert_com_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    comSel |-> (negSel == '0));

  assert_busy_drives_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> doEn);

  assert_sel_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable({posSel, negSel, comSel}));

  assert_trial_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (dacCode == TOP_BIT));

  assert_cs_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csHighCnt >= 5'(SYNC_STAGES + 1)) |-> (!busy && !doEn && posSel == '0));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !doEn |-> !doData);

endmodule

bind sar_serial_core sar_serial_chk #(
  .NUM_CH(NUM_CH), .RES(RES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_sar_serial_core.sv
`timescale 1ns/1ps
module sim_sar_serial_core;

  localparam int NUM_CH = 8;
  localparam int RES    = 8;
  localparam int HALF   = 8;   // system clocks per serial half-period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, din = 1'b0, shiftEn = 1'b0;
  logic cmpIn;
  logic [RES-1:0]    dacCode;
  logic [NUM_CH-1:0] posSel, negSel;
  logic comSel, busy, doData, doEn;

  int nChecks = 0;
  int nErrors = 0;
  int chV [NUM_CH];
  int comV;

  always #5 clk = ~clk;

  sar_serial_core #(.NUM_CH(NUM_CH), .RES(RES), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .shiftEn(shiftEn), .cmpIn(cmpIn), .dacCode(dacCode), .posSel(posSel),
    .negSel(negSel), .comSel(comSel), .busy(busy), .doData(doData), .doEn(doEn)
  );

  // analog front-end model: the selects route voltages to the comparator
  always_comb begin
    int pv, nv;
    pv = 0;
    nv = 0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (posSel[i]) pv = chV[i];
      if (negSel[i]) nv = chV[i];
    end
    if (comSel) nv = comV;
    cmpIn = ((pv - nv) >= int'(dacCode));
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expResult(bit mode, int idx);
    int d;
    d = chV[idx] - (mode ? comV : chV[idx ^ 1]);
    if (d < 0) d = 0;
    if (d > 255) d = 255;
    return d;
  endfunction

  task automatic halfHigh();
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic halfLow();
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  // one full transaction; abortAt < 0 means no abort
  task automatic convert(int lead, bit mode, int idx, int hold, int abortAt);
    logic [3:0] w;
    int exp, ePos, eNeg;
    w    = {mode, 3'(idx)};
    exp  = expResult(mode, idx);
    ePos = 1 << idx;
    eNeg = mode ? 0 : (1 << (idx ^ 1));
    csN = 1'b0;
    shiftEn = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < lead; i++) begin  // R2 leading zeros
      din = 1'b0; halfHigh(); halfLow();
    end
    din = 1'b1; halfHigh(); halfLow();
    for (int b = 3; b >= 0; b--) begin
      din = w[b];
      halfHigh();
      if (b != 0) halfLow();
    end
    check("R4 no drive before gap", int'(doEn), 0);
    din = 1'($urandom);
    halfLow();
    check("R4 gap drives", int'(doEn), 1);
    check("R4 gap zero", int'(doData), 0);
    check("R4 busy low in gap", int'(busy), 0);
    din = 1'($urandom);
    halfHigh();
    check("R4 busy rises", int'(busy), 1);
    check("R5 first trial", int'(dacCode), 128);
    check("R2 R3 posSel", int'(posSel), ePos);
    check("R3 negSel", int'(negSel), eNeg);
    check("R3 comSel", int'(comSel), int'(mode));
    for (int k = 0; k < RES; k++) begin
      din = 1'($urandom);                  // R8 noise on data-in
      halfLow();
      check("R5 decision bit", int'(doData), (exp >> (RES - 1 - k)) & 1);
      if (k == abortAt) begin
        csN = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 abort busy", int'(busy), 0);
        check("R9 abort doEn", int'(doEn), 0);
        check("R9 abort sel", int'(posSel), 0);
        return;
      end
      if (k == RES - 1) shiftEn = (hold > 0);
      halfHigh();
      check("R6 busy", int'(busy), (k < RES - 1) ? 1 : 0);
    end
    check("R8 sel kept", int'(posSel), ePos);
    for (int h = 0; h < hold; h++) begin
      halfLow();
      check("R7 LSB held", int'(doData), exp & 1);
      if (h == hold - 1) shiftEn = 1'b0;
      halfHigh();
    end
    for (int b = 1; b < RES; b++) begin
      halfLow();
      check("R7 LSB-first bit", int'(doData), (exp >> b) & 1);
      halfHigh();
    end
    for (int t = 0; t < 2; t++) begin
      halfLow();
      check("R7 tail zero", int'(doData), 0);
      check("R7 tail driven", int'(doEn), 1);
      halfHigh();
    end
    csN = 1'b1;
    sclk = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 idle doEn", int'(doEn), 0);
    check("R1 idle sel", int'({posSel, negSel, comSel}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL R1 watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NUM_CH; i++) chV[i] = 0;
    comV = 0;
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset doEn", int'(doEn), 0);
    check("R1 reset dac", int'(dacCode), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle sel", int'({posSel, negSel}), 0);

    // directed: negative difference yields zero (R5)
    chV[2] = 40; chV[3] = 90;
    convert(0, 1'b0, 2, 0, -1);
    // directed: full scale and reversed pair polarity
    chV[2] = 0; chV[3] = 255;
    convert(5, 1'b0, 3, 2, -1);
    // directed: single-ended against the common pin
    chV[7] = 200; comV = 55;
    convert(1, 1'b1, 7, 0, -1);
    // directed: abort in the middle, then a clean conversion (R9)
    convert(2, 1'b1, 7, 0, 3);
    chV[0] = 0; comV = 0;
    convert(0, 1'b1, 0, 1, -1);

    for (int n = 0; n < 25; n++) begin
      for (int i = 0; i < NUM_CH; i++) chV[i] = int'($urandom_range(255, 0));
      comV = int'($urandom_range(120, 0));
      convert(int'($urandom_range(3, 0)), 1'($urandom), int'($urandom_range(7, 0)),
              int'($urandom_range(3, 0)), (n % 7 == 6) ? int'($urandom_range(7, 0)) : -1);
    end

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule